// File: doc/BRIEF.md
# Serial-Load Full Convolution Engine

This block forms the complete discrete convolution of two eight-sample sequences of unsigned 8-bit values and delivers all fifteen outputs in order. A host writes the operands one pair at a time through a 16-bit load word. Each write carries one sample of the first sequence (X) in its low byte and the matching sample of the second sequence (Y) in its high byte. A single-cycle start pulse then runs the engine.

Output k is the sum over j of X[7-k+j]*Y[j], taken only where 0 <= 7-k+j <= 7. This is the convolution of the index-reversed X with Y, both treated as zero-padded to fifteen entries. The engine does not collect the results in a buffer. A combinational sum of eight gated products finishes one output per cycle, and that output is registered onto the 32-bit result port while the next one is being formed.

A 4-bit index register paces the run. A busy flag and a matching valid flag frame the fifteen output cycles.

Top module: `conv8_engine`

## Requirements
- R1: Each accepted load strobe stores the low byte of `load_word` (bits 7:0) as the next X element and the high byte (bits 15:8) as the next Y element. Elements fill in order from index 0 to 7.
- R2: Once eight pairs are stored, further strobes are ignored. An accepted start rewinds the fill position to element 0. Elements that are not rewritten after that keep their earlier values.
- R3: A start seen while idle raises `busy` and `result_valid` on the next cycle. Both stay high for exactly 15 cycles and then fall.
- R4: In the n-th busy cycle (n = 0..14), `result_out` equals the sum over j of X[7-n+j]*Y[j] over valid indices. With X = {1,4,5,8,6,9,11,2} and Y = {31,25,9,7,16,19,3,2} this gives hex 3e,187,23c,20c,24c,2ae,2d2,218,183,131,ca,7b,29,b,2.
- R5: `result_out` is zero-extended. Its bits 31:19 are always zero, since the largest output is 8*255*255 = 520200.
- R6: A start asserted while busy is ignored. The run neither restarts nor lengthens.
- R7: Load strobes while busy, or in the same cycle as an accepted start, change no stored operand.
- R8: `result_out` is zero whenever `busy` is low.
- R9: A synchronous active-low reset clears `busy`, `result_valid`, `result_out`, the fill position and both operand arrays. A run started straight after reset therefore yields fifteen zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_strobe | input | 1 | Store one operand pair from `load_word` |
| load_word | input | 16 | Low byte: X sample; high byte: Y sample |
| start | input | 1 | Begin a 15-cycle convolution run |
| busy | output | 1 | High during the 15 output cycles |
| result_valid | output | 1 | Qualifies `result_out`; equal to `busy` |
| result_out | output | 32 | Current convolution output, zero-extended |

## Verification
The hardest situations to reach are a start pulse or a load strobe that lands in the middle of a run, since a correct design shows no trace of either. The stimulus pulses start and a distinct load word together partway through one run. It then checks that this run finishes on time with unchanged values, and that a second run without reloading reproduces the same outputs. A partial reload after a full run checks that the fill position rewinds while the untouched elements keep their values. A reset issued mid-run, followed by an unloaded run, shows that the operand arrays were really cleared.

// File: rtl/conv8_pkg.sv
// Package conv8_pkg
// Shared defaults and the run-state type for the convolution engine.
// Assumes: unsigned samples; all modules take widths as parameters.
package conv8_pkg;
    localparam int DEF_SAMPLE_W = 8;
    localparam int DEF_TAPS     = 8;
    localparam int DEF_RESULT_W = 32;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/conv8_operand_bank.sv
// Module conv8_operand_bank
// Holds the two operand sequences and the fill position that loads them.
// Assumes: the caller masks wr_en during a run; rewind has priority over wr_en.
module conv8_operand_bank #(
    parameter int SAMPLE_W = 8,
    parameter int TAPS     = 8,
    localparam int WORD_W  = 2 * SAMPLE_W,
    localparam int PTR_W   = $clog2(TAPS + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           rewind,
    input  logic [WORD_W-1:0]              word,
    output logic [TAPS-1:0][SAMPLE_W-1:0]  x_vec,
    output logic [TAPS-1:0][SAMPLE_W-1:0]  y_vec
);
    logic [PTR_W-1:0] fill_q;
    logic             room;

    assign room = (fill_q < PTR_W'(TAPS));

    // Fill position: rewinds on start, advances on each stored pair, stops at TAPS.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (rewind) begin
            fill_q <= '0;
        end else if (wr_en && room) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    genvar e;
    generate
        for (e = 0; e < TAPS; e++) begin : g_elem
            // Element e captures its byte pair when the fill position points at it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    x_vec[e] <= '0;
                    y_vec[e] <= '0;
                end else if (!rewind && wr_en && (fill_q == PTR_W'(e))) begin
                    x_vec[e] <= word[SAMPLE_W-1:0];
                    y_vec[e] <= word[WORD_W-1:SAMPLE_W];
                end
            end
        end
    endgenerate

    // R2: fill position never passes the number of taps
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= PTR_W'(TAPS));

    // R2: a full bank ignores further strobes
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!room && !rewind) |=> ($stable(x_vec) && $stable(y_vec)));
endmodule

// File: rtl/conv8_sum_of_products.sv
// Module conv8_sum_of_products
// Combinational output k of the full convolution of reversed X with Y.
// Assumes: k in 0 .. 2*TAPS-2; other k values give gated (possibly zero) terms.
module conv8_sum_of_products #(
    parameter int SAMPLE_W = 8,
    parameter int TAPS     = 8,
    parameter int IDX_W    = 4,
    parameter int RESULT_W = 32,
    localparam int PROD_W  = 2 * SAMPLE_W,
    localparam int SEL_W   = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic [TAPS-1:0][SAMPLE_W-1:0] x_vec,
    input  logic [TAPS-1:0][SAMPLE_W-1:0] y_vec,
    input  logic [IDX_W-1:0]              k,
    output logic [RESULT_W-1:0]           sum
);
    logic [TAPS-1:0][PROD_W-1:0] term;

    genvar j;
    generate
        for (j = 0; j < TAPS; j++) begin : g_term
            int         x_pos;
            logic       in_range;
            logic [SEL_W-1:0] x_sel;

            // Tap j: pick reversed X element, zero the product outside the overlap.
            always_comb begin
                x_pos    = (TAPS - 1) + j - int'(k);
                in_range = (x_pos >= 0) && (x_pos <= TAPS - 1);
                x_sel    = SEL_W'(x_pos);
                term[j]  = in_range ? (PROD_W'(x_vec[x_sel]) * PROD_W'(y_vec[j])) : '0;
            end
        end
    endgenerate

    // Adder tree flattened into a loop: sums all gated products.
    always_comb begin
        sum = '0;
        for (int t = 0; t < TAPS; t++) begin
            sum = sum + RESULT_W'(term[t]);
        end
    end
endmodule

// File: rtl/conv8_sequencer.sv
// Module conv8_sequencer
// Runs the output index through one pass and registers each result.
// Assumes: sum_in reflects sel_idx combinationally within the same cycle.
module conv8_sequencer
    import conv8_pkg::*;
#(
    parameter int IDX_W    = 4,
    parameter int RESULT_W = 32,
    parameter int LAST     = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [RESULT_W-1:0] sum_in,
    output logic [IDX_W-1:0]    sel_idx,
    output logic                accept,
    output logic                busy,
    output logic [RESULT_W-1:0] result_q
);
    seq_state_t       state_q;
    logic [IDX_W-1:0] idx_q;
    logic             at_last;

    assign busy    = (state_q == SEQ_RUN);
    assign accept  = start && !busy;
    assign at_last = (idx_q == IDX_W'(LAST));
    // Next output to register: first on start, following one while running.
    assign sel_idx = busy ? (idx_q + 1'b1) : '0;

    // Run control and output register: one result per cycle, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            idx_q    <= '0;
            result_q <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        state_q  <= SEQ_RUN;
                        idx_q    <= '0;
                        result_q <= sum_in;
                    end
                end
                default: begin
                    if (at_last) begin
                        state_q  <= SEQ_IDLE;
                        idx_q    <= '0;
                        result_q <= '0;
                    end else begin
                        idx_q    <= idx_q + 1'b1;
                        result_q <= sum_in;
                    end
                end
            endcase
        end
    end

    // R3: an idle start opens a run at output 0
    a_r3_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && idx_q == '0));

    // R3: the run closes right after the last output
    a_r3_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && at_last) |=> !busy);

    // R6: a running pass steps by one whatever start does
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !at_last) |=> (busy && idx_q == IDX_W'($past(idx_q) + 1'b1)));

    // R8: output register reads zero outside a run
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (result_q == '0));
endmodule

// File: rtl/conv8_engine.sv
// Module conv8_engine
// Top of the serial-load convolution engine: operand bank, product sum, sequencer.
// Assumes: unsigned samples; operands are only written while no run is active.
module conv8_engine
    import conv8_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int TAPS     = DEF_TAPS,
    parameter int RESULT_W = DEF_RESULT_W,
    localparam int WORD_W  = 2 * SAMPLE_W,
    localparam int OUT_LEN = 2 * TAPS - 1,
    localparam int IDX_W   = $clog2(OUT_LEN + 1),
    localparam int SUM_W   = 2 * SAMPLE_W + $clog2(TAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_strobe,
    input  logic [WORD_W-1:0]   load_word,
    input  logic                start,
    output logic                busy,
    output logic                result_valid,
    output logic [RESULT_W-1:0] result_out
);
    logic [TAPS-1:0][SAMPLE_W-1:0] x_vec;
    logic [TAPS-1:0][SAMPLE_W-1:0] y_vec;
    logic [IDX_W-1:0]              sel_idx;
    logic [RESULT_W-1:0]           sum;
    logic                          accept;
    logic                          wr_en;

    // Loads are accepted only between runs.
    assign wr_en        = load_strobe && !busy;
    assign result_valid = busy;

    conv8_operand_bank #(
        .SAMPLE_W (SAMPLE_W),
        .TAPS     (TAPS)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rewind (accept),
        .word   (load_word),
        .x_vec  (x_vec),
        .y_vec  (y_vec)
    );

    conv8_sum_of_products #(
        .SAMPLE_W (SAMPLE_W),
        .TAPS     (TAPS),
        .IDX_W    (IDX_W),
        .RESULT_W (RESULT_W)
    ) u_sop (
        .x_vec (x_vec),
        .y_vec (y_vec),
        .k     (sel_idx),
        .sum   (sum)
    );

    conv8_sequencer #(
        .IDX_W    (IDX_W),
        .RESULT_W (RESULT_W),
        .LAST     (OUT_LEN - 1)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .sum_in   (sum),
        .sel_idx  (sel_idx),
        .accept   (accept),
        .busy     (busy),
        .result_q (result_out)
    );

    // R7: operands hold during a run even under load strobes
    a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load_strobe) |=> ($stable(x_vec) && $stable(y_vec)));

    // R5: no bits above the widest possible sum
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (result_out >> SUM_W) == '0);

    // R1: a strobe between runs changes at most one element pair
    a_r1_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($countones(x_vec ^ $past(x_vec)) <= SAMPLE_W));
endmodule

// File: tb/conv8_engine_tb.sv
`timescale 1ns/1ps
module conv8_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_strobe = 1'b0;
    logic [15:0] load_word = '0;
    logic        start = 1'b0;
    logic        busy;
    logic        result_valid;
    logic [31:0] result_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the operand state, kept from the requirements.
    logic [7:0] ma [8];
    logic [7:0] mb [8];
    int         mptr = 0;

    localparam logic [15:0] SETS [4][8] = '{
        '{16'h1F01, 16'h1904, 16'h0905, 16'h0708, 16'h1006, 16'h1309, 16'h030B, 16'h0202},
        '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
        '{16'h01FF, 16'h0200, 16'h0300, 16'h0400, 16'h0500, 16'h0600, 16'h0700, 16'hFF08},
        '{16'h0101, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000}
    };
    localparam logic [31:0] GOLD [15] = '{
        32'h3e, 32'h187, 32'h23c, 32'h20c, 32'h24c, 32'h2ae, 32'h2d2, 32'h218,
        32'h183, 32'h131, 32'hca, 32'h7b, 32'h29, 32'hb, 32'h2
    };

    conv8_engine u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_strobe  (load_strobe),
        .load_word    (load_word),
        .start        (start),
        .busy         (busy),
        .result_valid (result_valid),
        .result_out   (result_out)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] ref_out(int n);
        logic [31:0] s = '0;
        for (int j = 0; j < 8; j++) begin
            int d = n - j;
            if (d >= 0 && d <= 7) s = s + 32'(ma[7 - d]) * 32'(mb[j]);
        end
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; drives one strobe for one cycle.
    task automatic do_load(input logic [15:0] w);
        load_strobe = 1'b1;
        load_word   = w;
        if (mptr < 8) begin
            ma[mptr] = w[7:0];
            mb[mptr] = w[15:8];
            mptr++;
        end
        @(negedge clk);
        load_strobe = 1'b0;
        load_word   = '0;
    endtask

    // Start a run and check all 15 outputs; optionally compare to GOLD and inject mid-run traffic.
    task automatic run_check(input bit golden, input bit inject);
        logic [31:0] exp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mptr = 0;
        for (int n = 0; n < 15; n++) begin
            exp = ref_out(n);
            check(busy && result_valid, "R3 busy/valid in run", {30'd0, busy, result_valid}, 32'h3);
            check(result_out == exp, "R4 output value", result_out, exp);
            check(result_out[31:19] == '0, "R5 zero extension", result_out, exp);
            if (golden) check(result_out == GOLD[n], "R4 golden vector", result_out, GOLD[n]);
            if (inject && n == 5) begin
                start       = 1'b1;   // R6: ignored while busy
                load_strobe = 1'b1;   // R7: ignored while busy
                load_word   = 16'hABCD;
            end
            @(negedge clk);
            start       = 1'b0;
            load_strobe = 1'b0;
            load_word   = '0;
        end
        check(!busy && !result_valid, "R3/R6 run ends after 15", {31'd0, busy}, 32'h0);
        check(result_out == '0, "R8 idle output zero", result_out, 32'h0);
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin ma[i] = '0; mb[i] = '0; end
        repeat (3) @(negedge clk);
        check(!busy && !result_valid, "R9 reset busy", {31'd0, busy}, 32'h0);
        check(result_out == '0, "R9 reset output", result_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: no loads after reset -> all zeros
        run_check(1'b0, 1'b0);

        // R1/R2/R4: table walk, a ninth strobe is ignored (R2)
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 8; e++) do_load(SETS[s][e]);
            do_load(16'hDEAD);
            run_check(s == 0, s == 2);
            if (s == 2) run_check(1'b0, 1'b0); // R6/R7: same operands again
        end

        // R2: partial reload after rewind keeps elements 3..7
        do_load(16'h1122);
        do_load(16'h3344);
        do_load(16'h5566);
        run_check(1'b0, 1'b0);

        // R1/R4: random operand sets
        for (int r = 0; r < 6; r++) begin
            for (int e = 0; e < 8; e++) do_load(16'($urandom));
            run_check(1'b0, 1'b0);
        end

        // R9: reset in the middle of a run clears state and operands
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && result_out == '0, "R9 mid-run reset", result_out, 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin ma[i] = '0; mb[i] = '0; end
        mptr = 0;
        @(negedge clk);
        run_check(1'b0, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule